// File: doc/BRIEF.md
# Security-Banked Exception Priority Resolver

This block walks the exception state table of a small interrupt controller that splits exceptions between a secure and a non-secure world. It reports two things: the most urgent exception that is pending and enabled, and the most urgent priority among the exceptions that are active. A host loads the table through a synchronous write port. There are two banks. The non-secure bank holds every exception number. The secure bank holds extra copies of a fixed set of banked system exceptions.

After a start pulse the resolver reads one exception number per clock, from 1 up to NUM_EXC-1. In that clock it evaluates the secure copy first and the non-secure copy second. It turns each raw priority into a group priority. The grouping field it uses belongs to the security state the exception targets. When compression is enabled, non-secure priorities are moved into the less urgent half of the range. The results are registered and a one-cycle done strobe marks them as valid.

Top module: `sbank_prio_resolver`

## Requirements
- R1: After reset the outputs are as follows: pend_num is 0, pend_sbank is 0, pend_prio and act_prio are both 0x100 (the "none" value, less urgent than any real priority), and done is 0.
- R2: A start pulse sampled while busy is low begins a scan. done goes high for exactly one cycle on the NUM_EXC-th rising edge after the edge that accepted start. A start pulse sampled while busy is high is ignored.
- R3: The group priority of a non-negative raw priority is the raw value ANDed with 0xFF shifted left by (grouping field + 1). grp_s is used for exceptions that target secure state and grp_ns for all others.
- R4: When cfg_squash and cfg_sec_on are both 1 and an exception targets non-secure state, its masked value m becomes (m >> 1) + 0x80.
- R5: A negative raw priority (a two's-complement 10-bit value) is used unchanged, with no masking and no compression.
- R6: Exception numbers 3, 4, 6, 11, 14 and 15 are banked. Their secure-bank entry is evaluated only when cfg_sec_on is 1, and it always targets secure state. pend_sbank is 1 only when the winner is such a secure-bank entry.
- R7: When cfg_sec_on is 1, the non-banked target rules are these. A number at or above 16 targets secure state when its tgt_ns bit is 0. Numbers 2 and 5 target secure state unless cfg_ns_faults is 1. Number 7 targets secure state. Number 12 targets non-secure state. All other low numbers target secure state.
- R8: When cfg_sec_on is 0, every exception targets non-secure state, the secure bank is ignored and no compression is applied.
- R9: Candidates replace the current best only on a strictly smaller group priority, in scan order (ascending number, secure copy before non-secure copy). A lower number therefore wins a tie, and for the same number the secure copy wins.
- R10: A pending candidate must have both its enable and pending bits set. Any entry with its active bit set updates act_prio, whatever its enable bit. Number 0 is never scanned.
- R11: When no entry qualifies as pending, pend_num is 0, pend_sbank is 0 and pend_prio is 0x100. When no entry is active, act_prio is 0x100.
- R12: A write with wr_en at 1 stores the fields wr_enable, wr_pend, wr_act, wr_tgt_ns and wr_prio at number wr_num. The entry goes to the secure bank when wr_bank is 1 and to the non-secure bank when wr_bank is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Table write strobe |
| wr_bank | input | 1 | 1 = secure bank, 0 = non-secure bank |
| wr_num | input | IDX_W | Exception number written |
| wr_enable | input | 1 | Enable bit of the entry |
| wr_pend | input | 1 | Pending bit of the entry |
| wr_act | input | 1 | Active bit of the entry |
| wr_tgt_ns | input | 1 | Target-state bit (1 = non-secure), used for numbers >= 16 |
| wr_prio | input | 10 | Signed raw priority |
| cfg_sec_on | input | 1 | Security extension present |
| cfg_ns_faults | input | 1 | Numbers 2 and 5 target non-secure state |
| cfg_squash | input | 1 | Compress non-secure priorities |
| grp_s | input | 3 | Grouping field for secure targets |
| grp_ns | input | 3 | Grouping field for non-secure targets |
| start | input | 1 | Begin a scan |
| busy | output | 1 | Scan in progress |
| done | output | 1 | One-cycle strobe: results valid |
| pend_num | output | IDX_W | Winning pending exception number |
| pend_sbank | output | 1 | Winner came from the secure bank |
| pend_prio | output | 10 | Signed group priority of the winner |
| act_prio | output | 10 | Signed most urgent active group priority |

## Verification
The hardest case to reach is a tie decided by bank order. It needs the secure and non-secure copies of one banked number to end up with equal group priorities after each has been masked with its own grouping field, possibly after compression, while no lower number beats them. The stimulus gets there in two ways. Directed tables place identical priorities on both copies. A sweep runs over every pair of grouping fields and every combination of the three control flags, using random priorities whose high bits take only a few values, so that equal group priorities across banks and numbers occur often.

// File: rtl/sbank_pkg.sv
package sbank_pkg;
  localparam int RAW_W     = 8;
  localparam int PRIO_W    = RAW_W + 2;
  localparam int GRP_W     = 3;
  localparam int FIRST_IRQ = 16;
  localparam logic signed [PRIO_W-1:0] PRIO_NONE = 10'sd256;

  typedef struct packed {
    logic                     en;
    logic                     pend;
    logic                     act;
    logic                     tgt_ns;
    logic signed [PRIO_W-1:0] prio;
  } exc_ent_t;

  function automatic logic num_banked(input int unsigned n);
    return (n == 3) || (n == 4) || (n == 6) || (n == 11) || (n == 14) || (n == 15);
  endfunction

  // Target state of a non-banked entry (1 = secure)
  function automatic logic num_to_secure(input int unsigned n, input logic tgt_ns,
                                         input logic sec_on, input logic ns_faults);
    if (!sec_on)               return 1'b0;
    if (n >= FIRST_IRQ)        return !tgt_ns;
    if ((n == 2) || (n == 5))  return !ns_faults;
    if (n == 7)                return 1'b1;
    if (n == 12)               return 1'b0;
    return 1'b1;
  endfunction
endpackage

// File: rtl/sbank_table.sv
module sbank_table
  import sbank_pkg::*;
#(
  parameter int NUM_EXC = 32,
  localparam int IDX_W  = $clog2(NUM_EXC)
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic             wr_bank,
  input  logic [IDX_W-1:0] wr_idx,
  input  exc_ent_t         wr_ent,
  input  logic             rd_en,
  input  logic [IDX_W-1:0] rd_idx,
  output exc_ent_t         rd_ns,
  output exc_ent_t         rd_s
);
  exc_ent_t rd_q [2];

  // One simple dual-port memory per bank: synchronous write, registered read
  for (genvar b = 0; b < 2; b++) begin : g_bank
    exc_ent_t mem [NUM_EXC];

    always_ff @(posedge clk) begin
      if (wr_en && (wr_bank == b[0]))
        mem[wr_idx] <= wr_ent;
      if (rd_en)
        rd_q[b] <= mem[rd_idx];
    end
  end

  assign rd_ns = rd_q[0];
  assign rd_s  = rd_q[1];
endmodule

// File: rtl/sbank_grp.sv
module sbank_grp
  import sbank_pkg::*;
(
  input  logic signed [PRIO_W-1:0] raw,
  input  logic                     to_secure,
  input  logic [GRP_W-1:0]         grp_s,
  input  logic [GRP_W-1:0]         grp_ns,
  input  logic                     squash_on,
  output logic signed [PRIO_W-1:0] gprio
);
  logic [GRP_W-1:0] grp;
  logic [RAW_W:0]   mask;
  logic [RAW_W-1:0] masked;

  always_comb begin
    grp    = to_secure ? grp_s : grp_ns;
    mask   = {(RAW_W+1){1'b1}} << ({1'b0, grp} + 4'd1);
    masked = raw[RAW_W-1:0] & mask[RAW_W-1:0];
    if (raw < 0)
      gprio = raw;
    else if (squash_on && !to_secure)
      gprio = {2'b00, 1'b1, masked[RAW_W-1:1]};
    else
      gprio = {2'b00, masked};
  end
endmodule

// File: rtl/sbank_scan.sv
module sbank_scan
  import sbank_pkg::*;
#(
  parameter int NUM_EXC = 32,
  localparam int IDX_W  = $clog2(NUM_EXC)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     start,
  input  logic                     sec_on,
  input  logic                     ns_faults,
  input  logic                     squash,
  input  logic [GRP_W-1:0]         grp_s,
  input  logic [GRP_W-1:0]         grp_ns,
  output logic                     rd_en,
  output logic [IDX_W-1:0]         rd_idx,
  input  exc_ent_t                 rd_ns,
  input  exc_ent_t                 rd_s,
  output logic                     busy,
  output logic                     done,
  output logic [IDX_W-1:0]         pend_num,
  output logic                     pend_sbank,
  output logic signed [PRIO_W-1:0] pend_prio,
  output logic signed [PRIO_W-1:0] act_prio
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_EXC - 1);

  logic                     running, ev_vld;
  logic [IDX_W-1:0]         ev_idx;
  logic signed [PRIO_W-1:0] best_p, best_a;
  logic [IDX_W-1:0]         best_n;
  logic                     best_s;

  logic                     s_ok, ns_tsec, sq_on;
  logic signed [PRIO_W-1:0] gp_s, gp_n;
  logic signed [PRIO_W-1:0] p1, p2, a1, a2;
  logic [IDX_W-1:0]         n1, n2;
  logic                     s1, s2;
  logic                     unused_ok;

  assign unused_ok = &{1'b0, rd_s.tgt_ns};
  assign rd_en = running;
  assign busy  = running | ev_vld;
  assign sq_on = squash & sec_on;

  always_comb begin
    s_ok    = sec_on && num_banked(int'(ev_idx));
    ns_tsec = !num_banked(int'(ev_idx)) &&
              num_to_secure(int'(ev_idx), rd_ns.tgt_ns, sec_on, ns_faults);
  end

  // Group priority for each bank: the secure copy always targets secure state
  for (genvar b = 0; b < 2; b++) begin : g_grp
    if (b == 1) begin : g_sec
      sbank_grp u_grp (.raw(rd_s.prio), .to_secure(1'b1), .grp_s(grp_s),
                       .grp_ns(grp_ns), .squash_on(sq_on), .gprio(gp_s));
    end else begin : g_ns
      sbank_grp u_grp (.raw(rd_ns.prio), .to_secure(ns_tsec), .grp_s(grp_s),
                       .grp_ns(grp_ns), .squash_on(sq_on), .gprio(gp_n));
    end
  end

  // Two ordered compare stages: secure copy, then non-secure copy
  always_comb begin
    p1 = best_p; n1 = best_n; s1 = best_s; a1 = best_a;
    if (s_ok && rd_s.en && rd_s.pend && (gp_s < best_p)) begin
      p1 = gp_s; n1 = ev_idx; s1 = 1'b1;
    end
    if (s_ok && rd_s.act && (gp_s < best_a))
      a1 = gp_s;
    p2 = p1; n2 = n1; s2 = s1; a2 = a1;
    if (rd_ns.en && rd_ns.pend && (gp_n < p1)) begin
      p2 = gp_n; n2 = ev_idx; s2 = 1'b0;
    end
    if (rd_ns.act && (gp_n < a1))
      a2 = gp_n;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      running    <= 1'b0;
      rd_idx     <= '0;
      ev_vld     <= 1'b0;
      ev_idx     <= '0;
      best_p     <= PRIO_NONE;
      best_a     <= PRIO_NONE;
      best_n     <= '0;
      best_s     <= 1'b0;
      done       <= 1'b0;
      pend_num   <= '0;
      pend_sbank <= 1'b0;
      pend_prio  <= PRIO_NONE;
      act_prio   <= PRIO_NONE;
    end else begin
      done   <= 1'b0;
      ev_vld <= running;
      ev_idx <= rd_idx;
      if (start && !busy) begin
        running <= 1'b1;
        rd_idx  <= IDX_W'(1);
        best_p  <= PRIO_NONE;
        best_a  <= PRIO_NONE;
        best_n  <= '0;
        best_s  <= 1'b0;
      end else if (running) begin
        rd_idx <= rd_idx + 1'b1;
        if (rd_idx == LAST)
          running <= 1'b0;
      end
      if (ev_vld) begin
        best_p <= p2; best_n <= n2; best_s <= s2; best_a <= a2;
        if (ev_idx == LAST) begin
          pend_prio  <= p2;
          pend_num   <= n2;
          pend_sbank <= s2;
          act_prio   <= a2;
          done       <= 1'b1;
        end
      end
    end
  end

  assert_done_pulse_R2: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_empty_zero_R11: assert property (@(posedge clk) disable iff (rst)
    (done && (pend_prio == PRIO_NONE)) |-> ((pend_num == '0) && !pend_sbank));

  assert_sbank_banked_R6: assert property (@(posedge clk) disable iff (rst)
    (done && pend_sbank) |-> num_banked(int'(pend_num)));

  assert_squash_floor_R4: assert property (@(posedge clk) disable iff (rst)
    (ev_vld && sq_on && !ns_tsec && (rd_ns.prio >= 0)) |-> (gp_n >= 10'sd128));

  assert_neg_pass_R5: assert property (@(posedge clk) disable iff (rst)
    (ev_vld && (rd_s.prio < 0)) |-> (gp_s == rd_s.prio));

  assert_prio_bound_R1: assert property (@(posedge clk) disable iff (rst)
    (pend_prio <= PRIO_NONE) && (act_prio <= PRIO_NONE));
endmodule

// File: rtl/sbank_prio_resolver.sv
module sbank_prio_resolver
  import sbank_pkg::*;
#(
  parameter int NUM_EXC = 32,
  localparam int IDX_W  = $clog2(NUM_EXC)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wr_en,
  input  logic                     wr_bank,
  input  logic [IDX_W-1:0]         wr_num,
  input  logic                     wr_enable,
  input  logic                     wr_pend,
  input  logic                     wr_act,
  input  logic                     wr_tgt_ns,
  input  logic signed [PRIO_W-1:0] wr_prio,
  input  logic                     cfg_sec_on,
  input  logic                     cfg_ns_faults,
  input  logic                     cfg_squash,
  input  logic [GRP_W-1:0]         grp_s,
  input  logic [GRP_W-1:0]         grp_ns,
  input  logic                     start,
  output logic                     busy,
  output logic                     done,
  output logic [IDX_W-1:0]         pend_num,
  output logic                     pend_sbank,
  output logic signed [PRIO_W-1:0] pend_prio,
  output logic signed [PRIO_W-1:0] act_prio
);
  exc_ent_t         wr_ent, rd_ns, rd_s;
  logic             rd_en;
  logic [IDX_W-1:0] rd_idx;

  assign wr_ent = '{en: wr_enable, pend: wr_pend, act: wr_act,
                    tgt_ns: wr_tgt_ns, prio: wr_prio};

  sbank_table #(.NUM_EXC(NUM_EXC)) u_table (
    .clk(clk), .wr_en(wr_en), .wr_bank(wr_bank), .wr_idx(wr_num), .wr_ent(wr_ent),
    .rd_en(rd_en), .rd_idx(rd_idx), .rd_ns(rd_ns), .rd_s(rd_s));

  sbank_scan #(.NUM_EXC(NUM_EXC)) u_scan (
    .clk(clk), .rst(rst), .start(start), .sec_on(cfg_sec_on),
    .ns_faults(cfg_ns_faults), .squash(cfg_squash), .grp_s(grp_s), .grp_ns(grp_ns),
    .rd_en(rd_en), .rd_idx(rd_idx), .rd_ns(rd_ns), .rd_s(rd_s),
    .busy(busy), .done(done), .pend_num(pend_num), .pend_sbank(pend_sbank),
    .pend_prio(pend_prio), .act_prio(act_prio));

  assert_start_busy_R2: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> busy);
endmodule

// File: tb/sbank_prio_resolver_bench.sv
module sbank_prio_resolver_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NE = 20;
  localparam int IW = $clog2(NE);
  localparam int WATCHDOG = 190000;

  logic clk = 1'b0, rst = 1'b1;
  logic wr_en = 0, wr_bank = 0, wr_enable = 0, wr_pend = 0, wr_act = 0, wr_tgt_ns = 0;
  logic [IW-1:0] wr_num = '0;
  logic signed [9:0] wr_prio = '0;
  logic sec_on = 0, nsf = 0, sq = 0, start = 0;
  logic [2:0] gs = 0, gn = 0;
  logic busy, done, pend_sbank;
  logic [IW-1:0] pend_num;
  logic signed [9:0] pend_prio, act_prio;

  int checks = 0, fails = 0, cycles = 0;
  bit m_en[2][NE], m_pd[2][NE], m_ac[2][NE], m_tg[2][NE];
  int m_pr[2][NE];
  int e_num, e_sb, e_pp, e_ap;

  sbank_prio_resolver #(.NUM_EXC(NE)) u_sbank_prio_resolver (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_bank(wr_bank), .wr_num(wr_num),
    .wr_enable(wr_enable), .wr_pend(wr_pend), .wr_act(wr_act), .wr_tgt_ns(wr_tgt_ns),
    .wr_prio(wr_prio), .cfg_sec_on(sec_on), .cfg_ns_faults(nsf), .cfg_squash(sq),
    .grp_s(gs), .grp_ns(gn), .start(start), .busy(busy), .done(done),
    .pend_num(pend_num), .pend_sbank(pend_sbank), .pend_prio(pend_prio),
    .act_prio(act_prio));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d cycles, expected < %0d", cycles, WATCHDOG);
      summary();
    end
  end

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic bit banked(int n);
    return n == 3 || n == 4 || n == 6 || n == 11 || n == 14 || n == 15;
  endfunction

  function automatic bit to_sec(int n, int b);
    if (b == 1) return 1;
    if (!sec_on || banked(n)) return 0;
    if (n >= 16) return !m_tg[0][n];
    if (n == 2 || n == 5) return !nsf;
    if (n == 12) return 0;
    return 1;
  endfunction

  function automatic int gprio(int raw, bit ts);
    int g, m;
    if (raw < 0) return raw;
    g = ts ? int'(gs) : int'(gn);
    m = raw & ((255 << (g + 1)) & 255);
    if (!ts && sq && sec_on) m = m / 2 + 128;
    return m;
  endfunction

  task automatic ref_model();
    e_num = 0; e_sb = 0; e_pp = 256; e_ap = 256;
    for (int n = 1; n < NE; n++)
      for (int b = 1; b >= 0; b--) begin
        int p;
        if (b == 1 && !(sec_on && banked(n))) continue;
        p = gprio(m_pr[b][n], to_sec(n, b));
        if (m_en[b][n] && m_pd[b][n] && p < e_pp) begin
          e_pp = p; e_num = n; e_sb = b;
        end
        if (m_ac[b][n] && p < e_ap) e_ap = p;
      end
  endtask

  task automatic clear_model();
    for (int b = 0; b < 2; b++)
      for (int n = 0; n < NE; n++) begin
        m_en[b][n] = 0; m_pd[b][n] = 0; m_ac[b][n] = 0; m_tg[b][n] = 0; m_pr[b][n] = 0;
      end
  endtask

  task automatic set_ent(int b, int n, bit en, bit pd, bit ac, bit tg, int pr);
    m_en[b][n] = en; m_pd[b][n] = pd; m_ac[b][n] = ac; m_tg[b][n] = tg; m_pr[b][n] = pr;
  endtask

  task automatic push_all();
    for (int b = 0; b < 2; b++)
      for (int n = 0; n < NE; n++) begin
        wr_en = 1; wr_bank = b[0]; wr_num = IW'(n);
        wr_enable = m_en[b][n]; wr_pend = m_pd[b][n]; wr_act = m_ac[b][n];
        wr_tgt_ns = m_tg[b][n]; wr_prio = 10'(m_pr[b][n]);
        @(negedge clk);
      end
    wr_en = 0;
  endtask

  // Runs a scan; checks the latency (R2)
  task automatic run_scan();
    int cnt;
    start = 1;
    @(negedge clk);
    start = 0;
    cnt = 0;
    while (!done && cnt < 4 * NE) begin
      @(negedge clk);
      cnt++;
    end
    check("R2 done latency", cnt, NE);
  endtask

  task automatic check_outputs(string tag);
    ref_model();
    check({tag, " R9 pend_num"}, int'(pend_num), e_num);
    check({tag, " R6 pend_sbank"}, int'(pend_sbank), e_sb);
    check({tag, " R3 pend_prio"}, int'(pend_prio), e_pp);
    check({tag, " R10 act_prio"}, int'(act_prio), e_ap);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R1: reset state
    check("R1 pend_num", int'(pend_num), 0);
    check("R1 pend_sbank", int'(pend_sbank), 0);
    check("R1 pend_prio", int'(pend_prio), 256);
    check("R1 act_prio", int'(act_prio), 256);
    check("R1 done", int'(done), 0);

    // R11: empty table
    clear_model(); sec_on = 1; push_all(); run_scan();
    check("R11 empty num", int'(pend_num), 0);
    check("R11 empty prio", int'(pend_prio), 256);
    check("R11 empty act", int'(act_prio), 256);

    // R9/R12: same-number tie goes to the secure bank
    clear_model(); sec_on = 1; gs = 0; gn = 0;
    set_ent(1, 3, 1, 1, 0, 0, 'h40);
    set_ent(0, 3, 1, 1, 0, 0, 'h40);
    set_ent(0, 17, 1, 1, 0, 1, 'h40);
    push_all(); run_scan();
    check("R9 tie num", int'(pend_num), 3);
    check("R12 tie sbank", int'(pend_sbank), 1);

    // R8: security absent, secure copy ignored
    sec_on = 0; gn = 3; m_pr[0][3] = 'h4F;
    push_all(); run_scan();
    check("R8 num", int'(pend_num), 3);
    check("R8 sbank", int'(pend_sbank), 0);
    check("R8 prio", int'(pend_prio), 'h40);

    // R4: compression lets a secure 0x70 beat a non-secure 0x00
    clear_model(); sec_on = 1; sq = 1; gs = 0; gn = 0;
    set_ent(0, 16, 1, 1, 0, 1, 0);
    set_ent(0, 17, 1, 1, 0, 0, 'h70);
    push_all(); run_scan();
    check("R4 squash num", int'(pend_num), 17);
    check("R4 squash prio", int'(pend_prio), 'h70);
    sq = 0; run_scan();
    check("R4 nosquash num", int'(pend_num), 16);

    // R10: disabled pending is not a candidate but still counts as active
    clear_model(); set_ent(0, 18, 0, 1, 1, 1, 'h20); set_ent(0, 19, 1, 1, 0, 1, 'h60);
    push_all(); run_scan();
    check("R10 num", int'(pend_num), 19);
    check("R10 act", int'(act_prio), 'h20);

    // R5: negative raw priority passes through
    clear_model(); gn = 7; gs = 7; set_ent(0, 2, 1, 1, 1, 0, -2);
    push_all(); run_scan();
    check("R5 prio", int'(pend_prio), -2);
    check("R5 act", int'(act_prio), -2);

    // R7: target rules with number 5 and number 12
    clear_model(); sec_on = 1; gs = 7; gn = 0; nsf = 0;
    set_ent(0, 5, 1, 1, 0, 0, 'h30); set_ent(0, 12, 1, 1, 0, 0, 'h10);
    push_all(); run_scan();
    check("R7 secure fault num", int'(pend_num), 5);
    check("R7 secure fault prio", int'(pend_prio), 0);
    nsf = 1; run_scan();
    check("R7 ns fault num", int'(pend_num), 12);
    check("R7 ns fault prio", int'(pend_prio), 'h10);

    // R2: start while busy is ignored
    begin
      int seen;
      start = 1; @(negedge clk); start = 0;
      repeat (3) @(negedge clk);
      start = 1; @(negedge clk); start = 0;
      seen = 0;
      repeat (2 * NE + 4) begin
        if (done) seen++;
        @(negedge clk);
      end
      check("R2 single done", seen, 1);
    end

    // Sweep: all flag combinations and grouping pairs with random tables
    for (int f = 0; f < 8; f++)
      for (int a = 0; a < 8; a++)
        for (int c = 0; c < 8; c++) begin
          sec_on = f[0]; sq = f[1]; nsf = f[2]; gs = 3'(a); gn = 3'(c);
          for (int b = 0; b < 2; b++)
            for (int n = 0; n < NE; n++) begin
              int r, pr;
              r = $urandom % 16;
              pr = (r == 0) ? -1 : (r == 1) ? -2
                   : int'((($urandom % 4) << 6) | (($urandom % 4) << 1));
              set_ent(b, n, ($urandom % 3) != 0, ($urandom % 3) == 0,
                      ($urandom % 5) == 0, $urandom % 2, pr);
            end
          push_all(); run_scan();
          check_outputs("sweep");
        end

    summary();
  end
endmodule